// File: doc/BRIEF.md
# Dual Word FIFO With Service Thresholds

This block sits between a bus-target serial engine and a register bus. It holds two 32-bit word queues. The receive queue is filled by the engine and drained by register reads. The transmit queue is filled by register writes and drained by the engine. Each word carries four bus bytes. Each queue has a small encoded threshold, and its request line rises once the queue holds enough words (receive) or has enough free slots (transmit). This lets software move data in bursts rather than one word per interrupt.

Software sees four word-aligned locations, selected by `reg_addr[3:2]`. Upper address bits are not decoded.

| Index | Location |
|---|---|
| 0 | control |
| 1 | status (read only) |
| 2 | transmit data (write pushes) |
| 3 | receive data (read pops) |

The control location holds both threshold fields and two flush bits that act once and never store. The status location reports the receive word count and the transmit free-slot count in separate byte fields, together with sticky error flags. The queue depth is a parameter and need not be a power of two.

Top module: `wfifo_pair`

## Requirements
- R1: After reset, both queues are empty and all sticky flags are clear. Control reads 0 and `irq_rx_req` is 0. Status reports the transmit free count as the depth (saturated) and a receive count of 0.
- R2: Words leave each queue in the order they entered. Receive words enter on `eng_rx_push` and leave on reads of index 3. Transmit words enter on writes of index 2 and leave on `eng_tx_pop`.
- R3: `reg_rdata` holds the result of a read in the cycle after `reg_rd` is sampled. `eng_tx_data` holds the popped word in the cycle after `eng_tx_pop` is sampled.
- R4: Status bits [7:0] give the receive word count and bits [23:16] give the transmit free-slot count.
- R5: Control bits [5:4] hold the receive threshold code n, which means a level of n+1 words. `irq_rx_req` is 1 exactly when, at the previous clock edge, the receive count was at least that level.
- R6: Control bits [17:16] hold the transmit threshold code n, which means a level of n+1 free slots. `irq_tx_req` is 1 exactly when, at the previous clock edge, the free count was at least that level.
- R7: Writing control with bit 0 set empties the receive queue and clears its flags. Bit 1 does the same for the transmit queue. Both bits read back as 0. A flush cancels any push or pop to the same queue in that cycle.
- R8: A push to a full queue is discarded, leaving its contents unchanged, and sets a sticky overflow flag. The receive flag is status bit 8 and the transmit flag is bit 24. The flag stays set until that queue is flushed.
- R9: A pop from an empty queue returns 0, leaves the count at 0 and sets a sticky underflow flag. The receive flag is status bit 9 and the transmit flag is bit 25.
- R10: Both count fields saturate at 255 when the depth exceeds 255 words.
- R11: On a full queue, a push and a pop in the same cycle both take effect. The count stays at the depth and no overflow is flagged.
- R12: Control reads return the two threshold codes at their positions and 0 in every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe |
| reg_addr | input | ADDR_W | byte address, index in bits [3:2] |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data, one cycle after the read |
| eng_rx_push | input | 1 | engine pushes a received word |
| eng_rx_data | input | 32 | received word |
| eng_tx_pop | input | 1 | engine takes a word to send |
| eng_tx_data | output | 32 | word to send, one cycle after the pop |
| irq_rx_req | output | 1 | receive service request |
| irq_tx_req | output | 1 | transmit refill request |

## Verification
The hardest case to reach is a full receive queue that sees an engine push and a register pop in the same cycle. The bench fills the queue to its depth. It then drives both strobes in one cycle and expects the oldest word out, an unchanged count and no overflow flag. Draining the queue afterwards shows the new word at the tail. Saturation of the count fields needs a depth above 255, so a second, deeper instance is filled past that point. A forced overflow is followed by a full drain, which confirms that the discarded word never entered the queue.

// File: rtl/wfifo_pkg.sv
package wfifo_pkg;
  localparam int WORD_W = 32;
  localparam int TRIG_W = 2;

  // register indices (reg_addr[3:2])
  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_STAT = 2'd1;
  localparam logic [1:0] IDX_TXD  = 2'd2;
  localparam logic [1:0] IDX_RXD  = 2'd3;

  // control field positions
  localparam int RX_FLUSH_BIT = 0;
  localparam int TX_FLUSH_BIT = 1;
  localparam int RX_TRIG_LSB  = 4;
  localparam int TX_TRIG_LSB  = 16;

  // status field positions
  localparam int RX_CNT_LSB  = 0;
  localparam int RX_OVF_BIT  = 8;
  localparam int RX_UNF_BIT  = 9;
  localparam int TX_FREE_LSB = 16;
  localparam int TX_OVF_BIT  = 24;
  localparam int TX_UNF_BIT  = 25;

  function automatic logic [7:0] sat8(input logic [31:0] v);
    return (v > 32'd255) ? 8'hFF : v[7:0];
  endfunction
endpackage

// File: rtl/wfifo_core.sv
module wfifo_core #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  output logic [CW-1:0] count,
  output logic [CW-1:0] free,
  output logic          ovf,
  output logic          unf
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, empty, do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign free    = CW'(DEPTH) - count;
  assign do_pop  = pop & ~empty & ~flush;
  assign do_push = push & ~flush & (~full | do_pop);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_data <= '0;
    end else if (pop) begin
      pop_data <= do_pop ? mem[rd_ptr] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      if (push && !do_push) ovf <= 1'b1;
      if (pop && empty)     unf <= 1'b1;
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf && !flush |=> ovf);
  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    push && full && !pop && !flush |=> count == $past(count));
  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0) && !ovf && !unf);
  // R9
  empty_pop_zero_chk: assert property (@(posedge clk) disable iff (rst)
    pop && empty |=> pop_data == '0);
  // R11
  full_swap_chk: assert property (@(posedge clk) disable iff (rst)
    push && pop && full && !flush |=> (count == $past(count)) && $stable(ovf));
endmodule

// File: rtl/wfifo_trigger.sv
module wfifo_trigger #(
  parameter int CW     = 5,
  parameter int TRIG_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TRIG_W-1:0] code,
  input  logic [CW-1:0]     amount,
  output logic              req
);
  logic [31:0] level;
  assign level = 32'(code) + 32'd1;

  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= (32'(amount) >= level);
  end
endmodule

// File: rtl/wfifo_pair.sv
module wfifo_pair
  import wfifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              eng_rx_push,
  input  logic [31:0]       eng_rx_data,
  input  logic              eng_tx_pop,
  output logic [31:0]       eng_tx_data,
  output logic              irq_rx_req,
  output logic              irq_tx_req
);
  logic [1:0]        idx;
  logic [TRIG_W-1:0] rx_code_q, tx_code_q;
  logic              ctrl_wr, rx_flush, tx_flush, tx_push, rx_pop;
  logic [CW-1:0]     rx_count, rx_free, tx_count, tx_free;
  logic              rx_ovf, rx_unf, tx_ovf, tx_unf;
  logic [31:0]       rx_word, ctrl_word, stat_word, rd_other_q;
  logic              rd_is_rx_q;

  assign idx      = reg_addr[3:2];
  assign ctrl_wr  = reg_wr && (idx == IDX_CTRL);
  assign rx_flush = ctrl_wr && reg_wdata[RX_FLUSH_BIT];
  assign tx_flush = ctrl_wr && reg_wdata[TX_FLUSH_BIT];
  assign tx_push  = reg_wr && (idx == IDX_TXD);
  assign rx_pop   = reg_rd && (idx == IDX_RXD);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_code_q <= '0;
      tx_code_q <= '0;
    end else if (ctrl_wr) begin
      rx_code_q <= reg_wdata[RX_TRIG_LSB +: TRIG_W];
      tx_code_q <= reg_wdata[TX_TRIG_LSB +: TRIG_W];
    end
  end

  wfifo_core #(.DEPTH(DEPTH), .W(WORD_W)) u_rx (
    .clk(clk), .rst(rst), .flush(rx_flush),
    .push(eng_rx_push), .push_data(eng_rx_data),
    .pop(rx_pop), .pop_data(rx_word),
    .count(rx_count), .free(rx_free), .ovf(rx_ovf), .unf(rx_unf)
  );

  wfifo_core #(.DEPTH(DEPTH), .W(WORD_W)) u_tx (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .push(tx_push), .push_data(reg_wdata),
    .pop(eng_tx_pop), .pop_data(eng_tx_data),
    .count(tx_count), .free(tx_free), .ovf(tx_ovf), .unf(tx_unf)
  );

  wfifo_trigger #(.CW(CW), .TRIG_W(TRIG_W)) u_rx_trig (
    .clk(clk), .rst(rst), .code(rx_code_q), .amount(rx_count), .req(irq_rx_req)
  );

  wfifo_trigger #(.CW(CW), .TRIG_W(TRIG_W)) u_tx_trig (
    .clk(clk), .rst(rst), .code(tx_code_q), .amount(tx_free), .req(irq_tx_req)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[RX_TRIG_LSB +: TRIG_W] = rx_code_q;
    ctrl_word[TX_TRIG_LSB +: TRIG_W] = tx_code_q;
    stat_word = '0;
    stat_word[RX_CNT_LSB +: 8]  = sat8(32'(rx_count));
    stat_word[TX_FREE_LSB +: 8] = sat8(32'(tx_free));
    stat_word[RX_OVF_BIT] = rx_ovf;
    stat_word[RX_UNF_BIT] = rx_unf;
    stat_word[TX_OVF_BIT] = tx_ovf;
    stat_word[TX_UNF_BIT] = tx_unf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_is_rx_q <= 1'b0;
      rd_other_q <= '0;
    end else if (reg_rd) begin
      rd_is_rx_q <= (idx == IDX_RXD);
      case (idx)
        IDX_CTRL: rd_other_q <= ctrl_word;
        IDX_STAT: rd_other_q <= stat_word;
        default:  rd_other_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rd_is_rx_q ? rx_word : rd_other_q;

  // R5
  rx_irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rx_count == '0 |=> !irq_rx_req);
  // R6
  tx_irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    tx_free == '0 |=> !irq_tx_req);
  // R12
  ctrl_flush_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd && idx == IDX_CTRL |=> reg_rdata[1:0] == 2'b00);
  // R4
  rx_free_sum_chk: assert property (@(posedge clk) disable iff (rst)
    32'(rx_count) + 32'(rx_free) == DEPTH);
endmodule

// File: tb/test_wfifo_pair.sv
module test_wfifo_pair;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int DEEP  = 260;

  logic clk = 0, rst = 1;
  logic reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic eng_rx_push = 0, eng_tx_pop = 0;
  logic [31:0] eng_rx_data = 0, eng_tx_data;
  logic irq_rx_req, irq_tx_req;

  logic d_wr = 0, d_rd = 0, d_push = 0, d_pop = 0;
  logic [3:0] d_addr = 0;
  logic [31:0] d_rdata, d_txd;
  logic d_irq_rx, d_irq_tx;

  int checks = 0, failures = 0;
  logic [31:0] rx_exp[$], tx_exp[$];
  logic rx_arm = 0, tx_arm = 0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  wfifo_pair #(.DEPTH(DEPTH), .ADDR_W(4)) i_wfifo_pair (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_rx_push(eng_rx_push),
    .eng_rx_data(eng_rx_data), .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .irq_rx_req(irq_rx_req), .irq_tx_req(irq_tx_req));

  wfifo_pair #(.DEPTH(DEEP), .ADDR_W(4)) i_wfifo_pair_deep (
    .clk(clk), .rst(rst), .reg_wr(d_wr), .reg_rd(d_rd), .reg_addr(d_addr),
    .reg_wdata(32'd0), .reg_rdata(d_rdata), .eng_rx_push(d_push),
    .eng_rx_data(32'h5A5A_0000), .eng_tx_pop(d_pop), .eng_tx_data(d_txd),
    .irq_rx_req(d_irq_rx), .irq_tx_req(d_irq_tx));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // monitor: compares design output against scoreboard queues
  always @(negedge clk) begin
    if (rx_arm) chk("R2 R3 rx order", reg_rdata, (rx_exp.size() > 0) ? rx_exp.pop_front() : 32'hDEAD_BEEF);
    if (tx_arm) chk("R2 R3 tx order", eng_tx_data, (tx_exp.size() > 0) ? tx_exp.pop_front() : 32'hDEAD_BEEF);
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic reg_write(input logic [1:0] i, input logic [31:0] d);
    reg_wr = 1; reg_addr = {i, 2'b00}; reg_wdata = d; step(); reg_wr = 0;
  endtask

  task automatic reg_read(input logic [1:0] i, output logic [31:0] d);
    reg_rd = 1; reg_addr = {i, 2'b00}; step(); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic tx_write(input logic [31:0] d);
    tx_exp.push_back(d); reg_write(2'd2, d);
  endtask

  task automatic eng_push(input logic [31:0] d, input bit track);
    if (track) rx_exp.push_back(d);
    eng_rx_push = 1; eng_rx_data = d; step(); eng_rx_push = 0;
  endtask

  task automatic rx_pop_mon();
    reg_rd = 1; reg_addr = 4'hC; step(); reg_rd = 0;
    rx_arm = 1; @(negedge clk); #1 rx_arm = 0;
  endtask

  task automatic tx_pop_mon();
    eng_tx_pop = 1; step(); eng_tx_pop = 0;
    tx_arm = 1; @(negedge clk); #1 tx_arm = 0;
  endtask

  task automatic stat_field(input string req, input int lsb, input int w, input int exp);
    logic [31:0] s;
    reg_read(2'd1, s);
    chk(req, (s >> lsb) & ((32'd1 << w) - 1), 32'(exp));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1 rst = 0;
    step(); step();
    // R1 reset state
    reg_read(2'd1, rd); chk("R1 status", rd, 32'h0010_0000);
    reg_read(2'd0, rd); chk("R1 control", rd, 0);
    chk("R1 irq_rx", {31'd0, irq_rx_req}, 0);
    chk("R6 irq_tx at reset", {31'd0, irq_tx_req}, 1);

    // R2 R3 R4 receive order and count
    for (int i = 0; i < 5; i++) eng_push(32'hA000_0000 + i, 1);
    for (int i = 0; i < 3; i++) rx_pop_mon();
    stat_field("R4 rx count", 0, 8, 2);

    // R5 receive threshold level 3
    reg_write(2'd0, 32'h0000_0020);
    step(); step();
    chk("R5 below level", {31'd0, irq_rx_req}, 0);
    eng_push(32'hA000_0010, 1); step();
    chk("R5 at level", {31'd0, irq_rx_req}, 1);
    reg_read(2'd0, rd); chk("R12 ctrl readback", rd, 32'h0000_0020);
    for (int i = 0; i < 3; i++) rx_pop_mon();
    step();
    chk("R5 drained", {31'd0, irq_rx_req}, 0);

    // R6 transmit threshold level 4 free
    reg_write(2'd0, 32'h0003_0000);
    for (int i = 0; i < 12; i++) tx_write(32'hB000_0000 + i);
    step();
    chk("R6 free 4", {31'd0, irq_tx_req}, 1);
    tx_write(32'hB000_0100); step();
    chk("R6 free 3", {31'd0, irq_tx_req}, 0);
    stat_field("R4 tx free", 16, 8, 3);
    for (int i = 0; i < 13; i++) tx_pop_mon();

    // R8 receive overflow, dropped word never appears
    for (int i = 0; i < DEPTH; i++) eng_push(32'hC000_0000 + i, 1);
    eng_push(32'hCCCC_CCCC, 0);
    stat_field("R8 rx count full", 0, 8, DEPTH);
    stat_field("R8 rx ovf flag", 8, 1, 1);
    for (int i = 0; i < DEPTH; i++) rx_pop_mon();
    stat_field("R8 ovf sticky", 8, 1, 1);

    // R9 receive underflow
    reg_read(2'd3, rd); chk("R9 empty pop data", rd, 0);
    stat_field("R9 rx unf flag", 9, 1, 1);
    stat_field("R9 rx count zero", 0, 8, 0);

    // R7 flush receive, flags cleared, later data intact
    for (int i = 0; i < 3; i++) eng_push(32'hD000_0000 + i, 0);
    reg_write(2'd0, 32'h0003_0001);
    stat_field("R7 rx flushed", 0, 10, 0);
    reg_read(2'd0, rd); chk("R7 flush bit reads 0", rd, 32'h0003_0000);
    eng_push(32'hD000_0100, 1);
    rx_pop_mon();
    // R7 flush cancels a same-cycle push
    eng_rx_push = 1; eng_rx_data = 32'hEEEE_0000;
    reg_write(2'd0, 32'h0003_0001); eng_rx_push = 0;
    stat_field("R7 flush beats push", 0, 8, 0);

    // R9 R8 R7 transmit side
    tx_write(32'hE000_0001); tx_write(32'hE000_0002);
    reg_write(2'd0, 32'h0003_0002);
    tx_exp.delete();
    stat_field("R7 tx flushed", 16, 8, DEPTH);
    eng_tx_pop = 1; step(); eng_tx_pop = 0;
    chk("R9 tx empty pop data", eng_tx_data, 0);
    stat_field("R9 tx unf flag", 25, 1, 1);
    for (int i = 0; i < DEPTH + 1; i++) reg_write(2'd2, 32'hF000_0000 + i);
    stat_field("R8 tx ovf flag", 24, 1, 1);
    stat_field("R8 tx free zero", 16, 8, 0);
    reg_write(2'd0, 32'h0003_0002);
    stat_field("R7 tx flags clear", 24, 2, 0);

    // R11 full receive queue, push and pop together
    for (int i = 0; i < DEPTH; i++) eng_push(32'h1100_0000 + i, 1);
    rx_exp.push_back(32'h1100_00FF);
    eng_rx_push = 1; eng_rx_data = 32'h1100_00FF;
    reg_rd = 1; reg_addr = 4'hC; step();
    eng_rx_push = 0; reg_rd = 0;
    rx_arm = 1; @(negedge clk); #1 rx_arm = 0;
    stat_field("R11 count held", 0, 8, DEPTH);
    stat_field("R11 no ovf", 8, 1, 0);
    for (int i = 0; i < DEPTH; i++) rx_pop_mon();

    // R10 saturation on deep instance
    d_rd = 1; d_addr = 4'h4; step(); d_rd = 0;
    chk("R10 tx free saturates", (d_rdata >> 16) & 32'hFF, 32'hFF);
    d_push = 1; repeat (258) step(); d_push = 0;
    d_rd = 1; d_addr = 4'h4; step(); d_rd = 0;
    chk("R10 rx count saturates", d_rdata & 32'hFF, 32'hFF);

    step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule